// File: doc/BRIEF.md
# Network Status LED Driver

This block turns the link-state and traffic indications of an Ethernet port into drive levels for front-panel LEDs. A mode pin picks one of two layouts. The three-LED layout shows speed, a combined link/activity light and a combined duplex/collision light. The four-LED layout shows link at 100 Mb/s, link at 10 Mb/s, a dedicated activity light and the same duplex/collision light.

Activity and collision arrive as single-cycle pulses. Two pulse stretchers hold each one long enough to show at least one whole blink period. Two free-running dividers generate the blink phases from the known clock frequency: a slow phase that toggles every 50 ms (10 Hz) and a fast phase that toggles every 25 ms (20 Hz). While a collision is being shown, activity blinking is suppressed.

All pins are plain level or pulse control signals, so there is no valid/ready handshake and no back-pressure. The LED outputs are registered and follow the inputs with one clock of latency.

Top module: `netled_driver`

## Requirements
- R1: While `rst` is sampled high, every LED output is 0 from the next edge on. Both blink phases and both stretch counters restart from zero, and each blink phase is low when reset is released.
- R2: In three-LED mode (`layout_four`=0), `led_o[0]` equals `spd_100`.
- R3: In three-LED mode, `led_o[1]` is 0 when `link_up` is 0. With the link up it is steadily 1 when no activity is being shown, and it follows the slow blink phase while activity is shown.
- R4: Activity is shown only while the activity stretcher is active and the collision stretcher is not.
- R5: The duplex/collision LED is `led_o[2]` in three-LED mode and `led_o[3]` in four-LED mode. It follows the fast blink phase while a collision is shown, and otherwise equals `full_dup`.
- R6: In four-LED mode, `led_o[0]` = `link_up & spd_100` and `led_o[1]` = `link_up & ~spd_100`.
- R7: In four-LED mode, `led_o[2]` follows the slow blink phase while activity is shown with the link up, and is 0 otherwise.
- R8: In three-LED mode, `led_o[3]` is 0.
- R9: A `tx_act` or `rx_act` pulse keeps activity shown for 2*SLOW_TICKS cycles after the edge that samples it. A `col_det` pulse keeps a collision shown for 2*FAST_TICKS cycles. A new pulse reloads the full count.
- R10: SLOW_TICKS = CLK_HZ*50/1000 and FAST_TICKS = CLK_HZ*25/1000. Each blink phase toggles once every TICKS cycles. Outputs are registered with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of known frequency CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| layout_four | input | 1 | 0 selects the three-LED layout, 1 the four-LED layout |
| link_up | input | 1 | Link is good |
| spd_100 | input | 1 | 1 for 100 Mb/s, 0 for 10 Mb/s |
| full_dup | input | 1 | Full-duplex operation |
| tx_act | input | 1 | Transmit activity pulse |
| rx_act | input | 1 | Receive activity pulse |
| col_det | input | 1 | Collision pulse |
| led_o | output | 4 | LED drive lines, 1 = lit |

## Verification
The bench builds the block with CLK_HZ = 2000. This gives a 100-cycle slow toggle, a 50-cycle fast toggle and stretch windows of 200 and 100 cycles. At that size, several full blink periods, the expiry of a stretched pulse, the reload by a repeated pulse and the overlap of activity with collision all fit into a few thousand cycles. The default 125 MHz setting would need millions of cycles for a single toggle.

// File: rtl/netled_pkg.sv
package netled_pkg;
  typedef enum logic {
    LAYOUT_THREE = 1'b0,
    LAYOUT_FOUR  = 1'b1
  } layout_e;

  localparam int unsigned LED_COUNT = 4;
endpackage

// File: rtl/netled_blink.sv
module netled_blink #(
  parameter int unsigned TICKS = 100
) (
  input  logic clk,
  input  logic rst,
  output logic phase_o
);
  localparam int unsigned CW = (TICKS > 2) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;

  // R10: the phase only moves at the end of a full divider period
  a_r10_phase_steady: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != LAST) |=> $stable(phase_q));
  a_r10_phase_flips: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == LAST) |=> (phase_q != $past(phase_q)));
endmodule

// File: rtl/netled_stretch.sv
module netled_stretch #(
  parameter int unsigned HOLD = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_i,
  output logic active_o
);
  localparam int unsigned HW = $clog2(HOLD + 1);
  localparam logic [HW-1:0] LOAD = HW'(HOLD);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)                hold_q <= '0;
    else if (pulse_i)       hold_q <= LOAD;
    else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
  end

  assign active_o = (hold_q != '0);

  // R9: a sampled pulse is shown starting on the next cycle
  a_r9_pulse_shown: assert property (@(posedge clk) disable iff (rst)
    pulse_i |=> active_o);
  // R9: the window never grows without a new pulse
  a_r9_no_growth: assert property (@(posedge clk) disable iff (rst)
    (!pulse_i && hold_q != '0) |=> (hold_q < $past(hold_q)));
endmodule

// File: rtl/netled_map.sv
module netled_map
  import netled_pkg::*;
(
  input  layout_e         layout_i,
  input  logic            link_i,
  input  logic            spd_i,
  input  logic            fdx_i,
  input  logic            act_i,
  input  logic            col_i,
  input  logic            slow_i,
  input  logic            fast_i,
  output logic [LED_COUNT-1:0] led_n
);
  logic act_show;
  logic dup_col;

  always_comb begin
    act_show = act_i & ~col_i;
    dup_col  = col_i ? fast_i : fdx_i;
    led_n    = '0;
    if (layout_i == LAYOUT_THREE) begin
      led_n[0] = spd_i;
      led_n[1] = link_i & (act_show ? slow_i : 1'b1);
      led_n[2] = dup_col;
      led_n[3] = 1'b0;
    end else begin
      led_n[0] = link_i & spd_i;
      led_n[1] = link_i & ~spd_i;
      led_n[2] = link_i & act_show & slow_i;
      led_n[3] = dup_col;
    end
  end
endmodule

// File: rtl/netled_driver.sv
module netled_driver
  import netled_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned SLOW_MS   = 50,
  parameter int unsigned FAST_MS   = 25
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       layout_four,
  input  logic       link_up,
  input  logic       spd_100,
  input  logic       full_dup,
  input  logic       tx_act,
  input  logic       rx_act,
  input  logic       col_det,
  output logic [3:0] led_o
);
  localparam int unsigned SLOW_TICKS = (CLK_HZ / 1000) * SLOW_MS;
  localparam int unsigned FAST_TICKS = (CLK_HZ / 1000) * FAST_MS;
  localparam int unsigned NSRC = 2;
  localparam int unsigned HOLDS [NSRC] = '{2 * SLOW_TICKS, 2 * FAST_TICKS};

  logic slow_ph, fast_ph;
  logic [NSRC-1:0] src_pulse, src_active;
  logic [LED_COUNT-1:0] led_n, led_q;

  netled_blink #(.TICKS(SLOW_TICKS)) u_slow (.clk(clk), .rst(rst), .phase_o(slow_ph));
  netled_blink #(.TICKS(FAST_TICKS)) u_fast (.clk(clk), .rst(rst), .phase_o(fast_ph));

  assign src_pulse[0] = tx_act | rx_act;
  assign src_pulse[1] = col_det;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_stretch
      netled_stretch #(.HOLD(HOLDS[g])) u_str (
        .clk(clk), .rst(rst), .pulse_i(src_pulse[g]), .active_o(src_active[g])
      );
    end
  endgenerate

  netled_map u_map (
    .layout_i (layout_e'(layout_four)),
    .link_i   (link_up),
    .spd_i    (spd_100),
    .fdx_i    (full_dup),
    .act_i    (src_active[0]),
    .col_i    (src_active[1]),
    .slow_i   (slow_ph),
    .fast_i   (fast_ph),
    .led_n    (led_n)
  );

  always_ff @(posedge clk) begin
    if (rst) led_q <= '0;
    else     led_q <= led_n;
  end

  assign led_o = led_q;

  // R1: reset darkens every LED on the following edge
  a_r1_reset_dark: assert property (@(posedge clk)
    rst |=> (led_o == 4'b0000));
  // R8: spare line stays dark in the three-LED layout
  a_r8_spare_dark: assert property (@(posedge clk) disable iff (rst)
    !layout_four |=> !led_o[3]);
  // R6: the two link lights never light together
  a_r6_speed_exclusive: assert property (@(posedge clk) disable iff (rst)
    layout_four |=> $onehot0(led_o[1:0]));
  // R3: link light is dark when the link is down
  a_r3_link_down_dark: assert property (@(posedge clk) disable iff (rst)
    (!layout_four && !link_up) |=> !led_o[1]);
  // R2: speed light tracks the speed input
  a_r2_speed_follow: assert property (@(posedge clk) disable iff (rst)
    !layout_four |=> (led_o[0] == $past(spd_100)));
endmodule

// File: tb/netled_driver_test.sv
module netled_driver_test;
  localparam int unsigned HZ = 2000;
  localparam int S  = 100;  // slow toggle cycles
  localparam int F  = 50;   // fast toggle cycles
  localparam int HA = 200;  // activity window
  localparam int HC = 100;  // collision window

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic layout_four = 1'b0, link_up = 1'b0, spd_100 = 1'b0, full_dup = 1'b0;
  logic tx_act = 1'b0, rx_act = 1'b0, col_det = 1'b0;
  logic [3:0] led_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  netled_driver #(.CLK_HZ(HZ)) uut (
    .clk(clk), .rst(rst), .layout_four(layout_four), .link_up(link_up),
    .spd_100(spd_100), .full_dup(full_dup), .tx_act(tx_act), .rx_act(rx_act),
    .col_det(col_det), .led_o(led_o)
  );

  // behavioural reference model
  int s_cnt = 0, f_cnt = 0, a_hold = 0, c_hold = 0;
  bit s_ph = 0, f_ph = 0;
  logic [3:0] exp_led = 4'b0;
  bit exp_mode = 0;

  always @(posedge clk) begin
    bit act, col, dc;
    if (rst) begin
      s_cnt = 0; f_cnt = 0; a_hold = 0; c_hold = 0;
      s_ph = 0; f_ph = 0; exp_led = 4'b0;
    end else begin
      col = (c_hold > 0);
      act = (a_hold > 0) && !col;
      dc  = col ? f_ph : full_dup;
      exp_mode = layout_four;
      if (!layout_four)
        exp_led = {1'b0, dc, link_up && (act ? s_ph : 1'b1), spd_100};
      else
        exp_led = {dc, link_up && act && s_ph, link_up && !spd_100, link_up && spd_100};
      if (s_cnt == S - 1) begin s_cnt = 0; s_ph = !s_ph; end else s_cnt++;
      if (f_cnt == F - 1) begin f_cnt = 0; f_ph = !f_ph; end else f_cnt++;
      if (tx_act || rx_act) a_hold = HA; else if (a_hold > 0) a_hold--;
      if (col_det) c_hold = HC; else if (c_hold > 0) c_hold--;
    end
  end

  function automatic string tag(bit four, int i);
    if (!four) begin
      case (i)
        0: return "R2";
        1: return "R3 R4 R9 R10";
        2: return "R5 R9 R10";
        default: return "R8";
      endcase
    end else begin
      case (i)
        0, 1: return "R6";
        2: return "R7 R4 R9 R10";
        default: return "R5 R9";
      endcase
    end
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      for (int i = 0; i < 4; i++) begin
        tests++;
        if (led_o[i] !== exp_led[i]) begin
          fails++;
          $display("FAIL %s led_o[%0d] actual=%b expected=%b t=%0t",
                   ((exp_led == 4'b0 && rst) ? "R1" : tag(exp_mode, i)), i, led_o[i], exp_led[i], $time);
        end
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tx();
    tx_act = 1'b1; @(negedge clk); tx_act = 1'b0;
  endtask
  task automatic pulse_rx();
    rx_act = 1'b1; @(negedge clk); rx_act = 1'b0;
  endtask
  task automatic pulse_col();
    col_det = 1'b1; @(negedge clk); col_det = 1'b0;
  endtask

  task automatic direct(string req, logic [3:0] exp);
    tests++;
    if (led_o !== exp) begin
      fails++;
      $display("FAIL %s led_o actual=%b expected=%b", req, led_o, exp);
    end
  endtask

  initial begin
    link_up = 1'b1; spd_100 = 1'b1; full_dup = 1'b1;
    wait_cyc(5);
    direct("R1", 4'b0000);           // reset holds all dark
    rst = 1'b0;
    wait_cyc(3);
    direct("R2 R3 R5", 4'b0111);     // three-LED idle, link up, 100M, FD
    // R3 R9 R10: single tx pulse, blink across whole window
    pulse_tx();
    wait_cyc(HA + 40);
    // R3: rx pulse, then link drop mid-window
    pulse_rx();
    wait_cyc(60);
    link_up = 1'b0;
    wait_cyc(40);
    link_up = 1'b1; spd_100 = 1'b0; full_dup = 1'b0;
    wait_cyc(20);
    // R4 R5: activity then collision overlap
    pulse_tx();
    wait_cyc(30);
    pulse_col();
    wait_cyc(HC + 30);
    // R9: repeated pulses reload window
    for (int k = 0; k < 4; k++) begin pulse_rx(); wait_cyc(120); end
    wait_cyc(HA);
    // R1: reset mid-blink restarts phases
    pulse_tx();
    wait_cyc(37);
    rst = 1'b1; wait_cyc(2);
    direct("R1", 4'b0000);
    rst = 1'b0;
    // four-LED layout: R6 R7 R5
    layout_four = 1'b1; spd_100 = 1'b1; full_dup = 1'b1;
    wait_cyc(3);
    direct("R6 R5", 4'b1001);
    pulse_tx();
    wait_cyc(HA + 20);
    spd_100 = 1'b0;
    wait_cyc(3);
    direct("R6", 4'b1010);
    pulse_col(); pulse_rx();
    wait_cyc(HC + 50);
    full_dup = 1'b0;
    pulse_col();
    wait_cyc(HC + 10);
    link_up = 1'b0;
    pulse_rx();
    wait_cyc(80);
    direct("R6 R7", 4'b0000);
    link_up = 1'b1;
    wait_cyc(HA);
    // switch layouts mid-window: R8
    pulse_tx(); pulse_col();
    wait_cyc(30);
    layout_four = 1'b0;
    wait_cyc(150);
    layout_four = 1'b1;
    wait_cyc(50);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule